// File: doc/BRIEF.md
# Dual-Mode On-Chip Byte Store (Cache or Local RAM)

This block puts a 256-byte array next to the processor. Software chooses one of two uses for it. In cache mode the array sits transparently between the processor and external memory. Read misses fill whole lines automatically. Writes always reach external memory, and a policy field decides whether instruction fetches, data accesses, both or neither are cached. In local-memory mode the array answers a 256-byte address window whose base is programmable. Accesses to that window never reach the external bus, and all other addresses pass straight through.

The processor holds a request (address, write flag, fetch tag and write byte) until `cpu_ready` is high in a cycle. That cycle completes the access. The external port works the same way with `ext_req` and `ext_ready`. Two registers are written through a small configuration port. The mode register holds the local/cache bit and the policy. The base register holds address bits 23:8 of the local window.

The controller has three states. S_IDLE completes local-window accesses and cache read hits in the request's own cycle. It moves to S_FILL on a cacheable read miss and to S_EXT for every other access. S_FILL issues sixteen line reads and returns to S_IDLE after the last one. The request, which is still held, then hits. S_EXT runs one external transaction, completes the processor access in the cycle `ext_ready` is seen, and returns to S_IDLE.

Top module: `ocm_top`

## Requirements
- R1: After reset the block is in cache mode, the policy is both (11), the base is 0 and every line is invalid. `ext_req` and `cpu_ready` are low, so the first cacheable read is a miss.
- R2: A cacheable read that hits returns the stored byte with `cpu_ready` high in the request's first cycle and makes no external transaction.
- R3: A cacheable read miss makes 16 external reads of its line. They run in ascending address order from the line base, which is the address with bits 3:0 cleared. The line then becomes valid and the request completes with the correct byte. The cache is direct-mapped: the index is address bits 7:4 and the tag is bits 23:8, so two addresses with the same index and different tags evict each other.
- R4: In cache mode every write makes exactly one external write with the same address and byte. On a hit the line is updated. A write miss allocates nothing.
- R5: The policy is mode-register bits 2:1. 01 caches fetches only, meaning reads with `cpu_fetch`=1 and `cpu_we`=0. 10 caches data only, meaning every other access. 11 caches both and 00 caches neither. An access that the policy excludes makes a single external transaction of its own kind and leaves the lines unchanged.
- R6: Any write to the mode register (`cfg_sel`=0) invalidates every line.
- R7: Mode bit 0 = 1 selects local mode. A `cfg_sel`=1 write loads the base from `cfg_wdata`, which holds address bits 23:8. Window accesses are those whose bits 23:8 equal the base. They complete in their first cycle, use bits 7:0 as the array offset and make no external transaction. Array contents are kept when the base changes.
- R8: In local mode an access outside the window makes one external transaction and returns external data.
- R9: `ext_req` stays high with a stable address, write flag and byte until a cycle with `ext_ready`, and that cycle completes the transaction for any latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_addr | input | 24 | Processor byte address |
| cpu_we | input | 1 | 1 = write |
| cpu_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes this cycle |
| ext_req | output | 1 | External transaction request |
| ext_addr | output | 24 | External byte address |
| ext_we | output | 1 | External write |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte |
| ext_ready | input | 1 | External transaction completes this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = mode register, 1 = base register |
| cfg_wdata | input | 16 | Configuration data |

## Verification
The hardest behaviour to observe from the ports is that the array contents are right while no bus traffic shows it. Examples are a write hit that updates the line, a fill whose bytes later show up through the local window, and an invalidation that leaves no trace until the next read. The bench counts external transactions for each access and compares the count with a line-tag model. It also keeps a byte-level model of the array, updated by fills, write hits and local writes. Later reads through the local window then expose what earlier cache traffic left behind. The stimulus mixes directed sequences (conflicting tags, policy switches, base moves) with random accesses and random policy changes under random external latency.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FILL = 2'd1,
        S_EXT  = 2'd2
    } ocm_state_e;

    typedef enum logic [1:0] {
        POL_NONE  = 2'b00,
        POL_FETCH = 2'b01,
        POL_DATA  = 2'b10,
        POL_BOTH  = 2'b11
    } ocm_policy_e;
endpackage

// File: rtl/ocm_cfg.sv
module ocm_cfg
    import ocm_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [TAG_W-1:0] cfg_wdata,
    output logic             local_mode,
    output ocm_policy_e      policy,
    output logic [TAG_W-1:0] base,
    output logic             flush
);
    // any mode-register write invalidates the lines
    assign flush = cfg_we && !cfg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            local_mode <= 1'b0;
            policy     <= POL_BOTH;
            base       <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                base <= cfg_wdata;
            end else begin
                local_mode <= cfg_wdata[0];
                policy     <= ocm_policy_e'(cfg_wdata[2:1]);
            end
        end
    end
endmodule

// File: rtl/ocm_tags.sv
module ocm_tags #(
    parameter int LINES = 16,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag
);
    logic [LINES-1:0] valid;
    logic [TAG_W-1:0] tags [LINES];

    assign hit = valid[lk_idx] && (tags[lk_idx] == lk_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (flush) begin
            valid <= '0;
        end else if (set_en) begin
            valid[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tags[set_idx] <= set_tag;
    end

    // R6: a mode write leaves no valid line behind
    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid == '0));
endmodule

// File: rtl/ocm_data.sv
module ocm_data #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ocm_top.sv
module ocm_top
    import ocm_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8,
    parameter int LINE_BYTES = 16,
    parameter int LINES      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_fetch,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              ext_req,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_we,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ready,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-$clog2(LINE_BYTES*LINES)-1:0] cfg_wdata
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int ARR_W = OFS_W + IDX_W;
    localparam int DEPTH = LINE_BYTES * LINES;
    localparam int TAG_W = ADDR_W - ARR_W;

    ocm_state_e state, state_nx;
    logic [OFS_W-1:0] beat;

    logic              local_mode, flush, hit;
    ocm_policy_e       policy;
    logic [1:0]        pol_v;
    logic [TAG_W-1:0]  base;
    logic [IDX_W-1:0]  c_idx;
    logic [TAG_W-1:0]  c_tag;
    logic              in_win, allow, cacheable, rd_hit, last_beat;
    logic              arr_we, tag_set;
    logic [ARR_W-1:0]  arr_waddr;
    logic [DATA_W-1:0] arr_wdata, arr_rdata;

    assign c_idx     = cpu_addr[ARR_W-1:OFS_W];
    assign c_tag     = cpu_addr[ADDR_W-1:ARR_W];
    assign pol_v     = policy;
    assign in_win    = local_mode && (c_tag == base);
    assign allow     = (cpu_fetch && !cpu_we) ? pol_v[0] : pol_v[1];
    assign cacheable = !local_mode && allow;
    assign rd_hit    = cacheable && !cpu_we && hit;
    assign last_beat = (beat == {OFS_W{1'b1}});

    ocm_cfg #(.TAG_W(TAG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .local_mode(local_mode), .policy(policy),
        .base(base), .flush(flush)
    );

    ocm_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_idx(c_idx), .lk_tag(c_tag), .hit(hit),
        .set_en(tag_set), .set_idx(c_idx), .set_tag(c_tag)
    );

    ocm_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(cpu_addr[ARR_W-1:0]), .rdata(arr_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            beat  <= '0;
        end else begin
            state <= state_nx;
            if (state != S_FILL) beat <= '0;
            else if (ext_ready)  beat <= beat + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (cpu_req && !in_win && !rd_hit)
                    state_nx = (cacheable && !cpu_we) ? S_FILL : S_EXT;
            end
            S_FILL: if (ext_ready && last_beat) state_nx = S_IDLE;
            S_EXT:  if (ext_ready) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = arr_rdata;
        ext_req   = 1'b0;
        ext_we    = 1'b0;
        ext_addr  = cpu_addr;
        ext_wdata = cpu_wdata;
        arr_we    = 1'b0;
        arr_waddr = cpu_addr[ARR_W-1:0];
        arr_wdata = cpu_wdata;
        tag_set   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cpu_req && (in_win || rd_hit)) begin
                    cpu_ready = 1'b1;
                    arr_we    = cpu_we && in_win;
                end
            end
            S_FILL: begin
                ext_req   = 1'b1;
                ext_addr  = {c_tag, c_idx, beat};
                arr_we    = ext_ready;
                arr_waddr = {c_idx, beat};
                arr_wdata = ext_rdata;
                tag_set   = ext_ready && last_beat;
            end
            S_EXT: begin
                ext_req   = 1'b1;
                ext_we    = cpu_we;
                cpu_ready = ext_ready;
                cpu_rdata = ext_rdata;
                arr_we    = ext_ready && cpu_we && cacheable && hit;
            end
            default: ;
        endcase
    end

    // R7: window accesses finish at once and stay off the bus
    assert_local_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cpu_req && in_win) |-> (cpu_ready && !ext_req));

    // R9: a waiting line read keeps its address
    assert_fill_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL && !ext_ready) |=> $stable(ext_addr));

    // R3: the last beat ends the fill and the requester is never released mid-fill
    assert_fill_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL && ext_ready && last_beat) |=> (state == S_IDLE));
    assert_fill_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL) |-> !cpu_ready);

    // R4: external writes only ever come from a processor write
    assert_write_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_we) |-> (cpu_req && cpu_we));
endmodule

// File: tb/ocm_top_tb.sv
module ocm_top_tb;
    localparam int AW = 24;
    localparam int TW = AW - 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          cpu_req = 0, cpu_we = 0, cpu_fetch = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0, cpu_rdata;
    logic          cpu_ready;
    logic          ext_req, ext_we;
    logic [AW-1:0] ext_addr;
    logic [7:0]    ext_wdata;
    logic [7:0]    ext_rdata = '0;
    logic          ext_ready = 0;
    logic          cfg_we = 0, cfg_sel = 0;
    logic [TW-1:0] cfg_wdata = '0;

    ocm_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_fetch(cpu_fetch), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .ext_req(ext_req),
        .ext_addr(ext_addr), .ext_we(ext_we), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .ext_ready(ext_ready), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
    );

    int vecs = 0, fails = 0;
    logic [7:0] emem [int];
    logic [7:0] gmem [int];
    int wait_n = 0, ext_cnt = 0, fill_n = 0, prev_a = 0, first_a = 0;
    bit order_bad = 0;

    // bench model state
    bit [1:0] m_pol = 2'b11;
    bit       m_loc = 0;
    int       m_base = 0;
    bit [15:0] bvalid = '0;
    int       btag [16];
    logic [7:0] lram [256];
    bit       lknown [256];

    function automatic logic [7:0] seedval(int a);
        return 8'((a * 7) ^ (a >> 8) ^ (a >> 13) ^ 8'h5a);
    endfunction
    function automatic logic [7:0] gread(int a);
        if (gmem.exists(a)) return gmem[a];
        return seedval(a);
    endfunction
    function automatic logic [7:0] eread(int a);
        if (emem.exists(a)) return emem[a];
        return seedval(a);
    endfunction

    // external memory with random latency
    always @(negedge clk) begin
        if (ext_req) begin
            if (wait_n == 0) begin
                ext_ready = 1'b1;
                ext_rdata = eread(int'(ext_addr));
            end else begin
                ext_ready = 1'b0;
                wait_n--;
            end
        end else begin
            ext_ready = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst_n && ext_req && ext_ready) begin
            ext_cnt++;
            if (ext_we) emem[int'(ext_addr)] = ext_wdata;
            else begin
                if (fill_n > 0 && int'(ext_addr) != prev_a + 1) order_bad = 1;
                if (fill_n == 0) first_a = int'(ext_addr);
                prev_a = int'(ext_addr);
                fill_n++;
            end
            wait_n = $urandom_range(0, 2);
        end
    end

    task automatic check(string req, int act, int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(bit sel, int v);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = v[TW-1:0];
        @(negedge clk);
        cfg_we = 0;
        if (sel) m_base = v & 16'hffff;
        else begin
            m_loc = v[0]; m_pol = v[2:1]; bvalid = '0;
        end
    endtask

    task automatic access(input bit we, input bit fetch, input int a, input logic [7:0] wd,
                          output logic [7:0] rd, output int txns, output int waits);
        int c0;
        c0 = ext_cnt; fill_n = 0; order_bad = 0; waits = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_fetch = fetch; cpu_addr = a[AW-1:0]; cpu_wdata = wd;
        #1;
        while (!cpu_ready && waits < 2000) begin
            @(negedge clk); #1; waits++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        txns = ext_cnt - c0;
        cpu_req = 0;
    endtask

    // model-checked access
    task automatic op(bit we, bit fetch, int a, logic [7:0] wd, string req);
        int idx, tg, exp_t, txns, waits;
        logic [7:0] rd, expd;
        bit allow, known, filled;
        idx = (a >> 4) & 15; tg = (a >> 8) & 16'hffff;
        known = 1; filled = 0;
        if (m_loc && tg == m_base) begin
            exp_t = 0;
            if (we) begin lram[a & 255] = wd; lknown[a & 255] = 1; end
            expd = lram[a & 255]; known = lknown[a & 255];
        end else begin
            allow = (!we && fetch) ? m_pol[0] : m_pol[1];
            if (!m_loc && allow && !we) begin
                if (bvalid[idx] && btag[idx] == tg) exp_t = 0;
                else begin
                    exp_t = 16; filled = 1; bvalid[idx] = 1; btag[idx] = tg;
                    for (int k = 0; k < 16; k++) begin
                        lram[idx*16+k] = gread((a & ~15) + k);
                        lknown[idx*16+k] = 1;
                    end
                end
            end else begin
                exp_t = 1;
                if (we && !m_loc && allow && bvalid[idx] && btag[idx] == tg) begin
                    lram[a & 255] = wd; lknown[a & 255] = 1;
                end
            end
            if (we) gmem[a] = wd;
            expd = gread(a);
        end
        access(we, fetch, a, wd, rd, txns, waits);
        check({req, " transactions"}, txns, exp_t);
        if (!we && known) check({req, " read data"}, int'(rd), int'(expd));
        if (exp_t == 0) check({req, " same-cycle completion"}, waits, 0);
        if (filled) begin
            check({req, " fill base R3"}, first_a, a & ~15);
            check({req, " fill order R3"}, int'(order_bad), 0);
        end
        if (we && exp_t == 1) check({req, " write-through R4"}, int'(eread(a)), int'(wd));
    endtask

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h0c0ffee5));
        for (int i = 0; i < 256; i++) lknown[i] = 0;
        repeat (4) @(negedge clk);
        #1;
        check("R1 ext_req at reset", int'(ext_req), 0);
        check("R1 cpu_ready at reset", int'(cpu_ready), 0);
        rst_n = 1;

        // R1/R3: first read misses, then R2 hits
        op(0, 1, 'h001234, 0, "R1");
        op(0, 1, 'h001234, 0, "R2");
        op(0, 0, 'h001239, 0, "R2");
        // R4: write hit updates, write miss does not allocate
        op(1, 0, 'h001234, 8'hc3, "R4");
        op(0, 0, 'h001234, 0, "R4");
        op(1, 0, 'h004560, 8'h77, "R4");
        op(0, 0, 'h004560, 0, "R4");
        // R3: same index, different tag evicts
        op(0, 0, 'h00ab30, 0, "R3");
        op(0, 0, 'h001234, 0, "R3");
        op(0, 0, 'h001234, 0, "R3");

        // R5: policy variants, each write flushing (R6)
        cfg(0, 3'b010);
        op(0, 0, 'h001234, 0, "R5");
        op(0, 0, 'h001234, 0, "R5");
        op(0, 1, 'h001234, 0, "R6");
        op(0, 1, 'h001234, 0, "R5");
        cfg(0, 3'b100);
        op(0, 1, 'h002200, 0, "R5");
        op(0, 1, 'h002200, 0, "R5");
        op(0, 0, 'h002200, 0, "R5");
        op(0, 0, 'h002201, 0, "R5");
        cfg(0, 3'b000);
        op(0, 0, 'h002200, 0, "R5");
        op(0, 1, 'h002200, 0, "R5");
        op(1, 0, 'h002200, 8'h19, "R5");
        // R6: rewrite of same mode value still invalidates
        cfg(0, 3'b110);
        op(0, 0, 'h003310, 0, "R6");
        op(0, 0, 'h003310, 0, "R6");
        cfg(0, 3'b110);
        op(0, 0, 'h003310, 0, "R6");

        // R7/R8: local window
        cfg(1, 'h0123);
        cfg(0, 3'b111);
        op(0, 0, 'h012331, 0, "R7");
        op(1, 0, 'h012300, 8'h5e, "R7");
        op(1, 1, 'h0123ff, 8'ha1, "R7");
        op(0, 1, 'h012300, 0, "R7");
        op(0, 0, 'h0123ff, 0, "R7");
        op(0, 0, 'h001234, 0, "R8");
        op(1, 0, 'h001235, 8'h42, "R8");
        op(0, 0, 'h001235, 0, "R8");
        cfg(1, 'h0456);
        op(0, 0, 'h012300, 0, "R8");
        op(0, 0, 'h045600, 0, "R7");
        op(0, 0, 'h0456ff, 0, "R7");
        cfg(0, 3'b110);
        op(0, 0, 'h012300, 0, "R6");

        // random phase with random latency (R9)
        for (int n = 0; n < 500; n++) begin
            int tg, a, r;
            r = $urandom_range(0, 3);
            tg = (r == 0) ? 'h0012 : (r == 1) ? 'h0034 : (r == 2) ? 'h0456 : 'h00ab;
            a = (tg << 8) | $urandom_range(0, 255);
            if ($urandom_range(0, 39) == 0)
                cfg(0, ($urandom_range(0, 3) << 1) | ($urandom_range(0, 3) == 0 ? 1 : 0));
            op($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a,
               8'($urandom_range(0, 255)), "R9");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule